// File: doc/BRIEF.md
# Fixed-Priority Five-Input Interrupt Controller

This block sits next to a processor core and decides which interrupt, if any, the core takes at each instruction boundary. It watches five request lines: one critical request that cannot be masked, three vectored restart requests (high, middle and low), and one general request. Each line has its own sensitivity. The critical line needs a rising edge followed by a held level, and it re-arms only after it has gone low. The high restart line is caught by an edge latch. The middle and low restart lines are plain high levels. The general line is a plain level that depends only on the global enable.

The core pulses `boundary_i` when an instruction completes. The block then picks the highest-priority request that can be serviced. It raises `take_o` for one cycle, together with the restart address and a source code. For the general request it first pulses `gen_ack_o`. During that cycle an external responder drives a restart opcode of the form 11NNN111, and the block turns NNN into the address 8*NNN. Software controls the global enable with set and clear strobes. It loads the three restart masks and clears the edge latch through a mask-write word, and it reads masks, enable and pending restart requests on a status port. Stack handling, fetch and handler code belong to the core.

Top module: `irq_prio_ctrl`

## Requirements
- R1: At an accepted boundary, only the highest serviceable request is taken, in the fixed order critical, high, middle, low, general. `src_o` reports the source as 1 critical, 2 high, 3 middle, 4 low, 5 general and 0 none.
- R2: After reset the global enable is 0, all three masks are 1, both latches are clear and `take_o`, `gen_ack_o`, `vec_o` and `src_o` are 0. The critical request is therefore the only one that can be taken.
- R3: The critical request is taken only when a rising edge has been seen and the line is still high at the boundary. If the line drops before the boundary, nothing is taken. Once taken, it is not taken again until the line goes low and then high again.
- R4: A rising edge on the high restart line sets a latch whatever the mask and enable are. The latch stays set after the line falls and is cleared by taking that request, by a mask write with bit 4 set, or by reset. A new edge in the same cycle as a mask-write clear leaves the latch set.
- R5: The middle and low restart lines count only while they are high at the boundary. A pulse that has ended before the boundary is not remembered.
- R6: A mask write with bit 3 set loads bits 2:0 into the masks (bit 0 low, bit 1 middle, bit 2 high). With bit 3 clear the masks are unchanged. A restart request is serviced only when its mask is 0 and the global enable is 1.
- R7: The general request ignores the masks and needs only the enable. Its acceptance pulses `gen_ack_o` in the next cycle, and `opc_i` is sampled in that cycle. If the opcode has the form 11NNN111, `take_o` follows one cycle later with `vec_o` = 8*NNN and source 5. Any other opcode results in no take.
- R8: `take_o` is a one-cycle pulse in the cycle after the boundary. `vec_o` carries 0x0024 for critical, 0x003C for high, 0x0034 for middle and 0x002C for low.
- R9: `ien_set_i` sets the enable and `ien_clr_i` clears it; when both are high, clear wins. Taking a high, middle, low or general request clears the enable, even if `ien_set_i` is high in that cycle. Taking the critical request leaves the enable unchanged.
- R10: Nothing is taken or acknowledged without a boundary. A boundary that arrives during the acknowledge cycle of a general request is ignored.
- R11: `stat_o` holds the masks in bits 2:0, the enable in bit 3, the low and middle line levels in bits 4 and 5, and the high latch in bit 6.
- R12: Every request line passes through a two-flop synchronizer. A level raised between clock edges shows up on `stat_o` after the second rising edge and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crit_req_i | input | 1 | Nonmaskable critical request, edge plus level |
| hi_req_i | input | 1 | High restart request, edge latched |
| mid_req_i | input | 1 | Middle restart request, level |
| lo_req_i | input | 1 | Low restart request, level |
| gen_req_i | input | 1 | General request, level, enable only |
| boundary_i | input | 1 | Instruction-complete strobe |
| ien_set_i | input | 1 | Set global enable |
| ien_clr_i | input | 1 | Clear global enable |
| mask_wr_i | input | 1 | Mask-write strobe |
| mask_wdata_i | input | 5 | Mask-write word: [2:0] masks, [3] load masks, [4] clear high latch |
| opc_i | input | 8 | Restart opcode from responder during acknowledge |
| take_o | output | 1 | Take-interrupt strobe |
| vec_o | output | ADDR_W | Restart address |
| src_o | output | 3 | Source of the taken interrupt |
| gen_ack_o | output | 1 | General-request acknowledge |
| stat_o | output | 7 | Status word |

## Verification
The delicate collision is a mask write that clears the high latch in the very cycle the synchronized high line shows a new rising edge. The bench raises the line on a falling clock edge, counts two rising edges for the synchronizer, and then puts the clear on the cycle in which the edge is detected. It expects bit 6 of the status to remain 1, and a later clear with no edge to drop it to 0. A second collision sets the enable in the same cycle as a boundary that takes a maskable request. There the take must win and leave the enable at 0.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Source code reported with a taken interrupt
    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_CRIT = 3'd1,
        SRC_HI   = 3'd2,
        SRC_MID  = 3'd3,
        SRC_LO   = 3'd4,
        SRC_GEN  = 3'd5
    } irq_src_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_ACK  = 1'b1
    } irq_phase_e;

    // Request line positions inside the synchronized vector
    localparam int IDX_LO   = 0;
    localparam int IDX_MID  = 1;
    localparam int IDX_HI   = 2;
    localparam int IDX_GEN  = 3;
    localparam int IDX_CRIT = 4;
    localparam int NUM_REQ  = 5;

    // Restart (maskable vectored) inputs
    localparam int NUM_RST  = 3;

    // Mask-write word fields
    localparam int CMD_W        = 5;
    localparam int CMD_LOAD_BIT = 3;
    localparam int CMD_CLR_BIT  = 4;

    // Status word
    localparam int STAT_W = 7;

    // Restart opcode fields
    localparam int OPC_W       = 8;
    localparam int OPC_NNN_LSB = 3;
    localparam int OPC_NNN_W   = 3;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_req_cond.sv
module irq_req_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic crit_s_i,
    input  logic hi_s_i,
    input  logic take_crit_i,
    input  logic take_hi_i,
    input  logic hi_clr_i,
    output logic crit_pend_o,
    output logic hi_pend_o
);

    typedef struct packed {
        logic crit_prev;
        logic hi_prev;
        logic crit_armed;
        logic hi_latch;
    } cond_t;

    cond_t cond_d, cond_q;
    logic  crit_rise, hi_rise;

    assign crit_rise = crit_s_i & ~cond_q.crit_prev;
    assign hi_rise   = hi_s_i & ~cond_q.hi_prev;

    always_comb begin
        cond_d           = cond_q;
        cond_d.crit_prev = crit_s_i;
        cond_d.hi_prev   = hi_s_i;

        // Critical: armed by an edge, disarmed by a low level or by being taken
        if (!crit_s_i || take_crit_i) begin
            cond_d.crit_armed = 1'b0;
        end
        if (crit_rise) begin
            cond_d.crit_armed = 1'b1;
        end

        // High restart: a fresh edge outranks any clear in the same cycle
        if (take_hi_i || hi_clr_i) begin
            cond_d.hi_latch = 1'b0;
        end
        if (hi_rise) begin
            cond_d.hi_latch = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= '0;
        end else begin
            cond_q <= cond_d;
        end
    end

    assign crit_pend_o = cond_q.crit_armed & crit_s_i;
    assign hi_pend_o   = cond_q.hi_latch;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N_RST = NUM_RST
) (
    input  logic             crit_pend_i,
    input  logic [N_RST-1:0] rst_pend_i,
    input  logic [N_RST-1:0] mask_i,
    input  logic             gen_pend_i,
    input  logic             en_i,
    output irq_src_e         sel_o
);

    logic [N_RST-1:0] live;

    assign live = rst_pend_i & ~mask_i & {N_RST{en_i}};

    always_comb begin
        sel_o = SRC_NONE;
        if (crit_pend_i) begin
            sel_o = SRC_CRIT;
        end else if (|live) begin
            // Ascending scan: the highest index found last wins
            for (int i = 0; i < N_RST; i++) begin
                if (live[i]) begin
                    sel_o = irq_src_e'(3'(int'(SRC_LO) - i));
                end
            end
        end else if (en_i && gen_pend_i) begin
            sel_o = SRC_GEN;
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int              ADDR_W      = 16,
    parameter int              SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] VEC_CRIT  = 'h0024,
    parameter logic [ADDR_W-1:0] VEC_HI    = 'h003C,
    parameter logic [ADDR_W-1:0] VEC_MID   = 'h0034,
    parameter logic [ADDR_W-1:0] VEC_LO    = 'h002C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crit_req_i,
    input  logic              hi_req_i,
    input  logic              mid_req_i,
    input  logic              lo_req_i,
    input  logic              gen_req_i,
    input  logic              boundary_i,
    input  logic              ien_set_i,
    input  logic              ien_clr_i,
    input  logic              mask_wr_i,
    input  logic [4:0]        mask_wdata_i,
    input  logic [7:0]        opc_i,
    output logic              take_o,
    output logic [ADDR_W-1:0] vec_o,
    output logic [2:0]        src_o,
    output logic              gen_ack_o,
    output logic [6:0]        stat_o
);

    localparam int SHIFT = OPC_NNN_LSB;

    typedef struct packed {
        logic               en;
        logic [NUM_RST-1:0] mask;
        irq_phase_e         phase;
        logic               take;
        logic [ADDR_W-1:0]  vec;
        irq_src_e           src;
        logic               gen_ack;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [NUM_REQ-1:0] req_async, req_s;
    logic               crit_pend, hi_pend;
    logic               take_crit, take_hi;
    logic               hi_clr;
    logic               accept;
    logic               opc_ok;
    logic [OPC_NNN_W-1:0] opc_nnn;
    irq_src_e           sel;

    assign req_async[IDX_LO]   = lo_req_i;
    assign req_async[IDX_MID]  = mid_req_i;
    assign req_async[IDX_HI]   = hi_req_i;
    assign req_async[IDX_GEN]  = gen_req_i;
    assign req_async[IDX_CRIT] = crit_req_i;

    irq_sync #(
        .WIDTH  (NUM_REQ),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (req_async),
        .sync_o  (req_s)
    );

    assign hi_clr = mask_wr_i & mask_wdata_i[CMD_CLR_BIT];

    irq_req_cond cond_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .crit_s_i    (req_s[IDX_CRIT]),
        .hi_s_i      (req_s[IDX_HI]),
        .take_crit_i (take_crit),
        .take_hi_i   (take_hi),
        .hi_clr_i    (hi_clr),
        .crit_pend_o (crit_pend),
        .hi_pend_o   (hi_pend)
    );

    irq_arbiter #(
        .N_RST (NUM_RST)
    ) arb_i (
        .crit_pend_i (crit_pend),
        .rst_pend_i  ({hi_pend, req_s[IDX_MID], req_s[IDX_LO]}),
        .mask_i      (ctrl_q.mask),
        .gen_pend_i  (req_s[IDX_GEN]),
        .en_i        (ctrl_q.en),
        .sel_o       (sel)
    );

    assign accept  = boundary_i && (ctrl_q.phase == PH_IDLE);
    assign opc_nnn = opc_i[OPC_NNN_LSB +: OPC_NNN_W];
    assign opc_ok  = (opc_i[7:6] == 2'b11) && (opc_i[2:0] == 3'b111);

    always_comb begin
        ctrl_d         = ctrl_q;
        ctrl_d.take    = 1'b0;
        ctrl_d.gen_ack = 1'b0;
        ctrl_d.src     = SRC_NONE;
        ctrl_d.vec     = '0;
        take_crit      = 1'b0;
        take_hi        = 1'b0;

        // Enable strobes: clear outranks set
        if (ien_clr_i) begin
            ctrl_d.en = 1'b0;
        end else if (ien_set_i) begin
            ctrl_d.en = 1'b1;
        end

        if (mask_wr_i && mask_wdata_i[CMD_LOAD_BIT]) begin
            ctrl_d.mask = mask_wdata_i[NUM_RST-1:0];
        end

        if (ctrl_q.phase == PH_ACK) begin
            // Opcode sampled during the acknowledge cycle
            ctrl_d.phase = PH_IDLE;
            if (opc_ok) begin
                ctrl_d.take = 1'b1;
                ctrl_d.src  = SRC_GEN;
                ctrl_d.vec  = ADDR_W'({opc_nnn, {SHIFT{1'b0}}});
            end
        end else if (accept) begin
            unique case (sel)
                SRC_CRIT: begin
                    ctrl_d.take = 1'b1;
                    ctrl_d.src  = SRC_CRIT;
                    ctrl_d.vec  = VEC_CRIT;
                    take_crit   = 1'b1;
                end
                SRC_HI: begin
                    ctrl_d.take = 1'b1;
                    ctrl_d.src  = SRC_HI;
                    ctrl_d.vec  = VEC_HI;
                    ctrl_d.en   = 1'b0;
                    take_hi     = 1'b1;
                end
                SRC_MID: begin
                    ctrl_d.take = 1'b1;
                    ctrl_d.src  = SRC_MID;
                    ctrl_d.vec  = VEC_MID;
                    ctrl_d.en   = 1'b0;
                end
                SRC_LO: begin
                    ctrl_d.take = 1'b1;
                    ctrl_d.src  = SRC_LO;
                    ctrl_d.vec  = VEC_LO;
                    ctrl_d.en   = 1'b0;
                end
                SRC_GEN: begin
                    ctrl_d.phase   = PH_ACK;
                    ctrl_d.gen_ack = 1'b1;
                    ctrl_d.en      = 1'b0;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q         <= '0;
            ctrl_q.mask    <= '1;
            ctrl_q.phase   <= PH_IDLE;
            ctrl_q.src     <= SRC_NONE;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign take_o    = ctrl_q.take;
    assign vec_o     = ctrl_q.vec;
    assign src_o     = ctrl_q.src;
    assign gen_ack_o = ctrl_q.gen_ack;
    assign stat_o    = {hi_pend, req_s[IDX_MID], req_s[IDX_LO], ctrl_q.en, ctrl_q.mask};

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_CRIT = 'h0024,
    parameter logic [ADDR_W-1:0] VEC_HI   = 'h003C,
    parameter logic [ADDR_W-1:0] VEC_MID  = 'h0034,
    parameter logic [ADDR_W-1:0] VEC_LO   = 'h002C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boundary_i,
    input logic              mask_wr_i,
    input logic [4:0]        mask_wdata_i,
    input logic              take_o,
    input logic [ADDR_W-1:0] vec_o,
    input logic [2:0]        src_o,
    input logic              gen_ack_o,
    input logic [6:0]        stat_o
);

    // R1: take and acknowledge never coincide
    assert_take_ack_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_o, gen_ack_o}));

    // R10: a take follows a boundary or an acknowledge, an acknowledge follows a boundary
    assert_take_needs_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($past(boundary_i) || $past(gen_ack_o)));
    assert_ack_needs_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        gen_ack_o |-> $past(boundary_i));

    // R7: acknowledge is followed by a take from the general source or by nothing
    assert_ack_then_gen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gen_ack_o |=> (!take_o || src_o == SRC_GEN));

    // R8: fixed restart addresses
    assert_vec_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ((src_o == SRC_CRIT && vec_o == VEC_CRIT) ||
                    (src_o == SRC_HI   && vec_o == VEC_HI)   ||
                    (src_o == SRC_MID  && vec_o == VEC_MID)  ||
                    (src_o == SRC_LO   && vec_o == VEC_LO)   ||
                    (src_o == SRC_GEN  && vec_o[2:0] == 3'b000)));

    // R6: a maskable restart is taken only if enabled and unmasked at the boundary
    assert_hi_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && src_o == SRC_HI) |-> $past(stat_o[3] && !stat_o[2]));
    assert_mid_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && src_o == SRC_MID) |-> $past(stat_o[3] && !stat_o[1]));
    assert_lo_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && src_o == SRC_LO) |-> $past(stat_o[3] && !stat_o[0]));

    // R9: maskable take leaves the enable clear
    assert_take_clears_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && (src_o == SRC_HI || src_o == SRC_MID || src_o == SRC_LO)) |-> !stat_o[3]);

    // R3: no critical take in two consecutive cycles
    assert_crit_rearm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && src_o == SRC_CRIT) |=> !(take_o && src_o == SRC_CRIT));

    // R4: the high latch holds unless taken or cleared by a mask write
    assert_hi_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_o[6]) && !$past(mask_wr_i && mask_wdata_i[4]) &&
         !(take_o && src_o == SRC_HI)) |-> stat_o[6]);

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .VEC_CRIT (VEC_CRIT),
    .VEC_HI   (VEC_HI),
    .VEC_MID  (VEC_MID),
    .VEC_LO   (VEC_LO)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .boundary_i   (boundary_i),
    .mask_wr_i    (mask_wr_i),
    .mask_wdata_i (mask_wdata_i),
    .take_o       (take_o),
    .vec_o        (vec_o),
    .src_o        (src_o),
    .gen_ack_o    (gen_ack_o),
    .stat_o       (stat_o)
);

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        crit = 1'b0, hi = 1'b0, mid = 1'b0, lo = 1'b0, gen = 1'b0;
    logic        boundary = 1'b0, ien_set = 1'b0, ien_clr = 1'b0;
    logic        mask_wr = 1'b0;
    logic [4:0]  mask_wdata = '0;
    logic [7:0]  opc = '0;
    logic        take_o, gen_ack_o;
    logic [15:0] vec_o;
    logic [2:0]  src_o;
    logic [6:0]  stat_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .crit_req_i   (crit),
        .hi_req_i     (hi),
        .mid_req_i    (mid),
        .lo_req_i     (lo),
        .gen_req_i    (gen),
        .boundary_i   (boundary),
        .ien_set_i    (ien_set),
        .ien_clr_i    (ien_clr),
        .mask_wr_i    (mask_wr),
        .mask_wdata_i (mask_wdata),
        .opc_i        (opc),
        .take_o       (take_o),
        .vec_o        (vec_o),
        .src_o        (src_o),
        .gen_ack_o    (gen_ack_o),
        .stat_o       (stat_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        {crit, hi, mid, lo, gen} = '0;
        boundary = 1'b0; ien_set = 1'b0; ien_clr = 1'b0; mask_wr = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic mask_write(input logic [4:0] w);
        mask_wr = 1'b1; mask_wdata = w;
        tick(1);
        mask_wr = 1'b0;
    endtask

    task automatic en_set();
        ien_set = 1'b1;
        tick(1);
        ien_set = 1'b0;
    endtask

    task automatic pulse_boundary();
        boundary = 1'b1;
        tick(1);
        boundary = 1'b0;
    endtask

    function automatic logic [2:0] exp_src(input logic [4:0] r, input logic e, input logic [2:0] m);
        if (r[4])                return 3'd1;
        if (e && r[2] && !m[2])  return 3'd2;
        if (e && r[1] && !m[1])  return 3'd3;
        if (e && r[0] && !m[0])  return 3'd4;
        if (e && r[3])           return 3'd5;
        return 3'd0;
    endfunction

    function automatic logic [15:0] exp_vec(input logic [2:0] s);
        case (s)
            3'd1:    return 16'h0024;
            3'd2:    return 16'h003C;
            3'd3:    return 16'h0034;
            3'd4:    return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R2: reset state
        chk("R2 stat", 32'(stat_o), 32'h07);
        chk("R2 take", 32'(take_o), 0);
        chk("R2 ack", 32'(gen_ack_o), 0);
        chk("R2 vec", 32'(vec_o), 0);
        chk("R2 src", 32'(src_o), 0);
        // R2: only critical can be taken after reset
        {mid, lo, gen, hi} = 4'hF;
        tick(5);
        pulse_boundary();
        chk("R2 nothing maskable", 32'(take_o | gen_ack_o), 0);

        // R12: two-flop synchronizer latency
        do_reset();
        lo = 1'b1;
        tick(1);
        chk("R12 after one edge", 32'(stat_o[4]), 0);
        tick(1);
        chk("R12 after two edges", 32'(stat_o[4]), 1);

        // Near-exhaustive sweep: R1 R6 R7 R8 R9 R11
        for (int r = 0; r < 32; r++) begin
            for (int e = 0; e < 2; e++) begin
                for (int m = 0; m < 8; m++) begin
                    logic [2:0] s;
                    logic [2:0] nnn;
                    do_reset();
                    nnn = 3'(r + m);
                    opc = {2'b11, nnn, 3'b111};
                    mask_write({2'b01, 3'(m)});
                    if (e == 1) en_set();
                    {crit, gen, hi, mid, lo} = 5'(r);
                    tick(5);
                    chk("R11 status", 32'(stat_o),
                        32'({r[2], r[1], r[0], e[0], 3'(m)}));
                    s = exp_src(5'(r), e[0], 3'(m));
                    pulse_boundary();
                    if (s == 3'd5) begin
                        chk("R7 ack", 32'({gen_ack_o, take_o}), 32'b10);
                        tick(1);
                        chk("R7 take", 32'(take_o), 1);
                        chk("R7 src", 32'(src_o), 5);
                        chk("R7 vec", 32'(vec_o), 32'({nnn, 3'b000}));
                        chk("R9 gen clears en", 32'(stat_o[3]), 0);
                    end else begin
                        chk("R1 take", 32'({gen_ack_o, take_o}), 32'(s != 3'd0));
                        chk("R1 src", 32'(src_o), 32'(s));
                        chk("R8 vec", 32'(vec_o), 32'(exp_vec(s)));
                        chk("R9 en after take", 32'(stat_o[3]),
                            32'((s == 3'd0 || s == 3'd1) ? e[0] : 1'b0));
                    end
                    tick(1);
                    chk("R8 one-cycle pulse", 32'(take_o), 0);
                end
            end
        end

        // R3: critical re-arm and glitch rejection
        do_reset();
        en_set();
        crit = 1'b1;
        tick(4);
        pulse_boundary();
        chk("R3 first take", 32'(src_o), 1);
        chk("R9 crit keeps en", 32'(stat_o[3]), 1);
        tick(2);
        pulse_boundary();
        chk("R3 held line not retaken", 32'(take_o), 0);
        crit = 1'b0;
        tick(4);
        crit = 1'b1;
        tick(4);
        pulse_boundary();
        chk("R3 retaken after low-high", 32'({take_o, src_o}), 32'h9);
        crit = 1'b0;
        tick(4);
        crit = 1'b1;
        tick(4);
        crit = 1'b0;
        tick(4);
        pulse_boundary();
        chk("R3 dropped line not taken", 32'(take_o), 0);

        // R4: edge latch survives the pulse and is taken
        do_reset();
        mask_write(5'b01000);
        en_set();
        hi = 1'b1;
        tick(2);
        hi = 1'b0;
        tick(4);
        chk("R4 latched", 32'(stat_o[6]), 1);
        pulse_boundary();
        chk("R4 take", 32'({take_o, src_o}), 32'hA);
        chk("R4 cleared by take", 32'(stat_o[6]), 0);

        // R4: latch sets while masked and disabled; clear by mask write keeps masks (R6)
        do_reset();
        hi = 1'b1;
        tick(2);
        hi = 1'b0;
        tick(4);
        chk("R4 latched while masked", 32'(stat_o[6]), 1);
        mask_write(5'b10000);
        chk("R4 cleared by write", 32'(stat_o[6]), 0);
        chk("R6 masks kept without load", 32'(stat_o[2:0]), 32'h7);

        // R4: clear colliding with a new edge
        do_reset();
        hi = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        mask_wr = 1'b1; mask_wdata = 5'b10000;
        tick(1);
        mask_wr = 1'b0;
        chk("R4 edge beats clear", 32'(stat_o[6]), 1);
        hi = 1'b0;
        tick(3);
        mask_write(5'b10000);
        chk("R4 clear without edge", 32'(stat_o[6]), 0);

        // R5: level lines are not remembered
        do_reset();
        mask_write(5'b01000);
        en_set();
        mid = 1'b1; lo = 1'b1;
        tick(4);
        mid = 1'b0; lo = 1'b0;
        tick(4);
        pulse_boundary();
        chk("R5 ended pulse ignored", 32'(take_o), 0);
        chk("R5 en untouched", 32'(stat_o[3]), 1);

        // R9: enable strobes and collision with a take
        do_reset();
        ien_set = 1'b1; ien_clr = 1'b1;
        tick(1);
        ien_set = 1'b0; ien_clr = 1'b0;
        chk("R9 clear wins", 32'(stat_o[3]), 0);
        mask_write(5'b01000);
        en_set();
        mid = 1'b1;
        tick(4);
        ien_set = 1'b1; boundary = 1'b1;
        tick(1);
        ien_set = 1'b0; boundary = 1'b0;
        chk("R9 take beats set", 32'({take_o, src_o}), 32'hB);
        chk("R9 en after collision", 32'(stat_o[3]), 0);

        // R10: no boundary, no take; boundary during acknowledge ignored
        do_reset();
        mask_write(5'b01000);
        en_set();
        gen = 1'b1; mid = 1'b1;
        for (int i = 0; i < 10; i++) begin
            tick(1);
            chk("R10 idle without boundary", 32'(take_o | gen_ack_o), 0);
        end
        mid = 1'b0;
        opc = 8'hDF;
        tick(3);
        pulse_boundary();
        chk("R10 ack", 32'(gen_ack_o), 1);
        crit = 1'b1;
        en_set();
        chk("R7 take after ack", 32'({take_o, src_o}), 32'hD);
        chk("R7 vec from opcode", 32'(vec_o), 32'h18);
        tick(3);
        boundary = 1'b1;
        tick(1);
        boundary = 1'b0;
        chk("R10 crit after ack", 32'(src_o), 1);
        do_reset();
        mask_write(5'b01000);
        en_set();
        gen = 1'b1;
        crit = 1'b0;
        tick(4);
        pulse_boundary();
        chk("R10 ack again", 32'(gen_ack_o), 1);
        crit = 1'b1;
        boundary = 1'b1;
        tick(1);
        boundary = 1'b0;
        chk("R10 boundary in ack ignored", 32'(src_o), 5);
        tick(1);
        chk("R10 no extra take", 32'(take_o), 0);

        // R7: malformed opcode gives no take
        do_reset();
        en_set();
        opc = 8'h00;
        gen = 1'b1;
        tick(4);
        pulse_boundary();
        chk("R7 ack malformed", 32'(gen_ack_o), 1);
        tick(1);
        chk("R7 malformed no take", 32'(take_o), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule